// File: doc/BRIEF.md
# DMA Command Legality Checker and Transaction Splitter

This block sits between a command source and a memory bus. It takes one DMA request at a time. Each request names a local address, a remote address, a byte count and a two-bit service class. The block checks the byte count and the address alignment. A legal request is cut into bus transactions of at most 128 bytes. An illegal request produces a one-cycle error report and issues no transaction. The unit that queued the request does not wait for the work to finish.

A request can also be marked as a list. In that case the byte count and remote address on the command port are unused. Instead, the block pulls elements one by one from a separate element port, and each element supplies a remote address and a byte count. The local address starts at the command's local address and moves forward by each element's byte count. A list holds between 1 and 2048 elements. An element that fails the checks stops the list and reports its zero-based position. An element with a byte count of zero is skipped without issuing anything.

Top module: `dma_cmd_splitter`

## Requirements
- R1: After reset, cmd_ready is 1, and txn_valid, elem_ready and err_valid are all 0.
- R2: The only legal byte counts are 0, 1, 2, 4, 8 and every multiple of 16 up to 16384. Any other count produces err_code 1 and issues no transaction.
- R3: A count below 16 needs both addresses aligned to the count. A count of 16 or more needs both addresses aligned to 16. A violation produces err_code 2 and issues no transaction. A count that is illegal reports code 1, even if the addresses are also misaligned.
- R4: A legal count below 16 gives exactly one transaction of that size. A larger count gives a series of transactions, each of size min(remaining, 128 - (remote address mod 128)). Both addresses advance by each transaction's size, so no transaction crosses a 128-byte remote boundary.
- R5: Every transaction carries the class given with its command, unchanged.
- R6: While txn_valid is 1 and txn_ready is 0, txn_valid and all transaction fields stay unchanged.
- R7: When cmd_list is 1, the block requests cmd_count elements in order over the element port. A count of 0 or above 2048 produces err_code 3. The local address of the first element is cmd_laddr, and each later element starts at the previous local address plus the previous element's count. After the last element, the block returns to accepting commands.
- R8: A list element that breaks R2 or R3 produces that error code with err_list 1 and err_index set to the element's zero-based position. No further element is requested, and the block returns to accepting commands.
- R9: A byte count of zero, on a single command or on a list element, issues no transaction. The block moves straight on to the next element or command.
- R10: err_valid is a one-cycle pulse in the cycle after the failing handshake. err_list is 0 for errors on the command itself. A legal command or element raises no pulse.
- R11: At most one of cmd_ready, elem_ready and txn_valid is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when also valid |
| cmd_list | input | 1 | 1: command describes an element list |
| cmd_laddr | input | 32 | Local start address |
| cmd_raddr | input | 32 | Remote address (single command) |
| cmd_size | input | 15 | Byte count (single command) |
| cmd_class | input | 2 | Service class |
| cmd_count | input | 12 | Number of list elements |
| elem_valid | input | 1 | List element offered |
| elem_ready | output | 1 | Element accepted when also valid |
| elem_raddr | input | 32 | Element remote address |
| elem_size | input | 15 | Element byte count |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken when also valid |
| txn_laddr | output | 32 | Transaction local address |
| txn_raddr | output | 32 | Transaction remote address |
| txn_size | output | 8 | Transaction byte count, 1 to 128 |
| txn_class | output | 2 | Transaction service class |
| err_valid | output | 1 | Error pulse |
| err_code | output | 2 | 1 size, 2 alignment, 3 list count |
| err_list | output | 1 | Error came from a list element |
| err_index | output | 11 | Position of the failing element |

## Verification
Some properties are checked by assertions on every cycle. Transactions stay stable under backpressure. No transaction exceeds 128 bytes or crosses a 128-byte remote boundary. Small transactions are naturally aligned. The three handshake phases never overlap. No transaction or element request is issued in an error cycle. The list index stays below the element count.

Other behaviour can only be shown by the bench's scenarios:
- the exact sequence of chunk addresses and sizes;
- that an illegal request issues nothing at all;
- the precedence between size and alignment errors;
- the running local address across list elements;
- that zero-size elements are skipped;
- the abort position, including index 2047 in a full 2048-element list.

// File: rtl/dmas_pkg.sv
package dmas_pkg;

    localparam int ADDR_W    = 32;
    localparam int SIZE_W    = 15;
    localparam int MAX_BYTES = 16384;
    localparam int CHUNK_B   = 128;
    localparam int CHK_W     = $clog2(CHUNK_B) + 1;
    localparam int OFS_W     = $clog2(CHUNK_B);
    localparam int LIST_MAX  = 2048;
    localparam int CNT_W     = $clog2(LIST_MAX) + 1;
    localparam int IDX_W     = $clog2(LIST_MAX);
    localparam int CLS_W     = 2;
    localparam int QUAD_B    = 16;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SIZE  = 2'd1,
        ERR_ALIGN = 2'd2,
        ERR_COUNT = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ELEM  = 2'd1,
        ST_SPLIT = 2'd2
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] laddr;
        logic [ADDR_W-1:0] raddr;
        logic [SIZE_W-1:0] rem;
    } xfer_t;

    // Legal byte counts: 0, 1, 2, 4, 8 or quad multiples up to the limit.
    function automatic logic size_legal(input logic [SIZE_W-1:0] s);
        logic small_ok;
        logic quad_ok;
        small_ok = (s == SIZE_W'(1)) || (s == SIZE_W'(2)) ||
                   (s == SIZE_W'(4)) || (s == SIZE_W'(8));
        quad_ok  = (s[3:0] == 4'd0) && (s <= SIZE_W'(MAX_BYTES));
        return small_ok || quad_ok;
    endfunction

    // Natural alignment for an already legal count.
    function automatic logic addr_aligned(input logic [ADDR_W-1:0] a,
                                          input logic [SIZE_W-1:0] s);
        logic [3:0] mask;
        if (s == '0)
            return 1'b1;
        if (s >= SIZE_W'(QUAD_B))
            return a[3:0] == 4'd0;
        mask = s[3:0] - 4'd1;
        return (a[3:0] & mask) == 4'd0;
    endfunction

endpackage

// File: rtl/dmas_check.sv
module dmas_check
    import dmas_pkg::*;
(
    input  logic [ADDR_W-1:0] laddr,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [SIZE_W-1:0] size,
    output err_e              verdict
);
    always_comb begin
        if (!size_legal(size))
            verdict = ERR_SIZE;
        else if (!addr_aligned(laddr, size) || !addr_aligned(raddr, size))
            verdict = ERR_ALIGN;
        else
            verdict = ERR_NONE;
    end
endmodule

// File: rtl/dmas_chunk.sv
module dmas_chunk
    import dmas_pkg::*;
(
    input  logic [ADDR_W-1:0] raddr,
    input  logic [SIZE_W-1:0] rem,
    output logic [CHK_W-1:0]  chunk,
    output logic              last
);
    logic [CHK_W-1:0] room;

    always_comb begin
        room = CHK_W'(CHUNK_B) - {1'b0, raddr[OFS_W-1:0]};
        if (rem < SIZE_W'(QUAD_B))
            chunk = rem[CHK_W-1:0];
        else if (rem < SIZE_W'(room))
            chunk = rem[CHK_W-1:0];
        else
            chunk = room;
        last = (rem == SIZE_W'(chunk));
    end
endmodule

// File: rtl/dma_cmd_splitter.sv
module dma_cmd_splitter
    import dmas_pkg::*;
#(
    parameter int LIST_LIMIT = dmas_pkg::LIST_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_list,
    input  logic [31:0]       cmd_laddr,
    input  logic [31:0]       cmd_raddr,
    input  logic [14:0]       cmd_size,
    input  logic [1:0]        cmd_class,
    input  logic [11:0]       cmd_count,
    input  logic              elem_valid,
    output logic              elem_ready,
    input  logic [31:0]       elem_raddr,
    input  logic [14:0]       elem_size,
    output logic              txn_valid,
    input  logic              txn_ready,
    output logic [31:0]       txn_laddr,
    output logic [31:0]       txn_raddr,
    output logic [7:0]        txn_size,
    output logic [1:0]        txn_class,
    output logic              err_valid,
    output logic [1:0]        err_code,
    output logic              err_list,
    output logic [10:0]       err_index
);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIST_LIMIT);

    state_e             state_q;
    xfer_t              cur_q;
    logic [CLS_W-1:0]   cls_q;
    logic               list_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   idx_q;
    logic               errv_q;
    err_e               errc_q;
    logic               errl_q;
    logic [IDX_W-1:0]   erri_q;

    logic [ADDR_W-1:0]  chk_l;
    logic [ADDR_W-1:0]  chk_r;
    logic [SIZE_W-1:0]  chk_s;
    err_e               verdict;
    logic [CHK_W-1:0]   chunk;
    logic               chunk_last;
    logic               elem_last;

    always_comb begin
        if (state_q == ST_ELEM) begin
            chk_l = cur_q.laddr;
            chk_r = elem_raddr;
            chk_s = elem_size;
        end else begin
            chk_l = cmd_laddr;
            chk_r = cmd_raddr;
            chk_s = cmd_size;
        end
    end

    dmas_check u_check (
        .laddr   (chk_l),
        .raddr   (chk_r),
        .size    (chk_s),
        .verdict (verdict)
    );

    dmas_chunk u_chunk (
        .raddr (cur_q.raddr),
        .rem   (cur_q.rem),
        .chunk (chunk),
        .last  (chunk_last)
    );

    assign elem_last  = (idx_q == cnt_q - CNT_W'(1));
    assign cmd_ready  = (state_q == ST_IDLE);
    assign elem_ready = (state_q == ST_ELEM);
    assign txn_valid  = (state_q == ST_SPLIT);
    assign txn_laddr  = cur_q.laddr;
    assign txn_raddr  = cur_q.raddr;
    assign txn_size   = chunk;
    assign txn_class  = cls_q;
    assign err_valid  = errv_q;
    assign err_code   = errc_q;
    assign err_list   = errl_q;
    assign err_index  = erri_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            cls_q   <= '0;
            list_q  <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            errv_q  <= 1'b0;
            errc_q  <= ERR_NONE;
            errl_q  <= 1'b0;
            erri_q  <= '0;
        end else begin
            errv_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cls_q <= cmd_class;
                        if (cmd_list) begin
                            if (cmd_count == '0 || cmd_count > LIMIT_C) begin
                                errv_q <= 1'b1;
                                errc_q <= ERR_COUNT;
                                errl_q <= 1'b0;
                                erri_q <= '0;
                            end else begin
                                list_q      <= 1'b1;
                                cnt_q       <= cmd_count;
                                idx_q       <= '0;
                                cur_q.laddr <= cmd_laddr;
                                state_q     <= ST_ELEM;
                            end
                        end else if (verdict != ERR_NONE) begin
                            errv_q <= 1'b1;
                            errc_q <= verdict;
                            errl_q <= 1'b0;
                            erri_q <= '0;
                        end else if (cmd_size != '0) begin
                            list_q  <= 1'b0;
                            cur_q   <= '{laddr: cmd_laddr, raddr: cmd_raddr,
                                         rem: cmd_size};
                            state_q <= ST_SPLIT;
                        end
                    end
                end
                ST_ELEM: begin
                    if (elem_valid) begin
                        if (verdict != ERR_NONE) begin
                            errv_q  <= 1'b1;
                            errc_q  <= verdict;
                            errl_q  <= 1'b1;
                            erri_q  <= idx_q[IDX_W-1:0];
                            state_q <= ST_IDLE;
                        end else if (elem_size == '0) begin
                            if (elem_last)
                                state_q <= ST_IDLE;
                            else
                                idx_q <= idx_q + CNT_W'(1);
                        end else begin
                            cur_q.raddr <= elem_raddr;
                            cur_q.rem   <= elem_size;
                            state_q     <= ST_SPLIT;
                        end
                    end
                end
                ST_SPLIT: begin
                    if (txn_ready) begin
                        cur_q.laddr <= cur_q.laddr + ADDR_W'(chunk);
                        cur_q.raddr <= cur_q.raddr + ADDR_W'(chunk);
                        cur_q.rem   <= cur_q.rem - SIZE_W'(chunk);
                        if (chunk_last) begin
                            if (list_q && !elem_last) begin
                                idx_q   <= idx_q + CNT_W'(1);
                                state_q <= ST_ELEM;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_TXN_HOLD: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_laddr) &&
        $stable(txn_raddr) && $stable(txn_size) && $stable(txn_class)); // R6

    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> txn_size != '0 && txn_size <= 8'(CHUNK_B)); // R4

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
        txn_valid && txn_size >= 8'(QUAD_B) |->
        ({2'b0, txn_raddr[OFS_W-1:0]} + {1'b0, txn_size}) <= 9'(CHUNK_B)); // R4

    AST_SMALL_ALIGN: assert property (@(posedge clk) disable iff (rst)
        txn_valid && txn_size < 8'(QUAD_B) |->
        (txn_raddr[3:0] & (txn_size[3:0] - 4'd1)) == 4'd0); // R3

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_ready, elem_ready, txn_valid})); // R11

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> !txn_valid && !elem_ready); // R8

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        elem_ready |-> idx_q < cnt_q); // R7

endmodule

// File: tb/dma_cmd_splitter_bench.sv
module dma_cmd_splitter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_list = 1'b0;
    logic [31:0] cmd_laddr = '0, cmd_raddr = '0;
    logic [14:0] cmd_size = '0;
    logic [1:0]  cmd_class = '0;
    logic [11:0] cmd_count = '0;
    logic        elem_valid = 1'b0;
    logic [31:0] elem_raddr = '0;
    logic [14:0] elem_size = '0;
    logic        txn_ready = 1'b0;
    logic        cmd_ready, elem_ready, txn_valid;
    logic [31:0] txn_laddr, txn_raddr;
    logic [7:0]  txn_size;
    logic [1:0]  txn_class;
    logic        err_valid, err_list;
    logic [1:0]  err_code;
    logic [10:0] err_index;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int unsigned q_l[$], q_r[$], q_s[$];
    int unsigned el_r[$], el_s[$];

    always #5 clk = ~clk;

    dma_cmd_splitter u_dma_cmd_splitter (.*);

    task automatic chk(input bit ok, input string tag,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ref_err(int unsigned l, int unsigned r, int unsigned s);
        bit legal = (s == 1 || s == 2 || s == 4 || s == 8) ||
                    (s % 16 == 0 && s <= 16384);
        if (!legal) return 1;
        if (s == 0) return 0;
        if (s < 16) return ((l % s) != 0 || (r % s) != 0) ? 2 : 0;
        return ((l % 16) != 0 || (r % 16) != 0) ? 2 : 0;
    endfunction

    function automatic void plan(int unsigned l, int unsigned r, int unsigned s);
        int unsigned rem = s;
        while (rem > 0) begin
            int unsigned c;
            if (rem < 16) c = rem;
            else c = (rem < 128 - (r % 128)) ? rem : 128 - (r % 128);
            q_l.push_back(l); q_r.push_back(r); q_s.push_back(c);
            l += c; r += c; rem -= c;
        end
    endfunction

    task automatic collect(input int cls);
        bit pend = 1'b0;
        logic [31:0] sr = '0, sl = '0;
        logic [7:0]  ss = '0;
        int waited = 0;
        while (q_s.size() > 0 && waited < 4000) begin
            bit rdy;
            @(negedge clk);
            waited++;
            if (pend) begin
                chk(txn_valid && txn_raddr == sr && txn_laddr == sl && txn_size == ss,
                    "R6 held txn", txn_raddr, sr);
                pend = 1'b0;
            end
            rdy = ($urandom % 4) != 0;
            txn_ready = rdy;
            if (txn_valid) begin
                if (rdy) begin
                    chk(txn_raddr == q_r[0], "R4 raddr", txn_raddr, q_r[0]);
                    chk(txn_laddr == q_l[0], "R4 laddr", txn_laddr, q_l[0]);
                    chk(txn_size == q_s[0], "R4 size", txn_size, q_s[0]);
                    chk(txn_class == cls, "R5 class", txn_class, cls);
                    void'(q_r.pop_front()); void'(q_l.pop_front()); void'(q_s.pop_front());
                end else begin
                    pend = 1'b1; sr = txn_raddr; sl = txn_laddr; ss = txn_size;
                end
            end
        end
        chk(q_s.size() == 0, "R4 missing txns", q_s.size(), 0);
        q_s.delete(); q_r.delete(); q_l.delete();
        @(negedge clk);
        txn_ready = 1'b0;
        chk(!txn_valid, "R4 extra txn", txn_valid, 0);
    endtask

    task automatic send_cmd(input bit lst, input int unsigned l, input int unsigned r,
                            input int unsigned s, input int cls, input int cnt,
                            input int exp_e, input string tag);
        int w = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_list = lst; cmd_laddr = l; cmd_raddr = r;
        cmd_size = 15'(s); cmd_class = 2'(cls); cmd_count = 12'(cnt);
        while (!cmd_ready && w < 1000) begin @(negedge clk); w++; end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_e != 0) begin
            chk(err_valid && err_code == exp_e, tag, err_code, exp_e);
            chk(!err_list, "R10 err_list single", err_list, 0);
            chk(!txn_valid && cmd_ready, {tag, " no txn"}, txn_valid, 0);
            @(negedge clk);
            chk(!err_valid, "R10 pulse width", err_valid, 0);
        end else begin
            chk(!err_valid, "R10 no error", err_valid, 0);
            if (!lst && s == 0) chk(!txn_valid && cmd_ready, "R9 zero cmd", txn_valid, 0);
        end
    endtask

    task automatic run_single(input int unsigned l, input int unsigned r,
                              input int unsigned s, input int cls);
        int e = ref_err(l, r, s);
        send_cmd(1'b0, l, r, s, cls, 0, e, (e == 1) ? "R2 size error" : "R3 align error");
        if (e == 0 && s != 0) begin
            plan(l, r, s);
            collect(cls);
        end
    endtask

    task automatic run_list(input int unsigned l0, input int cls);
        int unsigned lc = l0;
        int n = el_s.size();
        bit aborted = 1'b0;
        send_cmd(1'b1, l0, 0, 0, cls, n, 0, "R7 list accept");
        for (int i = 0; i < n; i++) begin
            int e = ref_err(lc, el_r[i], el_s[i]);
            int w = 0;
            @(negedge clk);
            elem_valid = 1'b1; elem_raddr = el_r[i]; elem_size = 15'(el_s[i]);
            while (!elem_ready && w < 1000) begin @(negedge clk); w++; end
            @(negedge clk);
            elem_valid = 1'b0;
            if (e != 0) begin
                chk(err_valid && err_code == e, "R8 elem code", err_code, e);
                chk(err_list, "R8 err_list", err_list, 1);
                chk(err_index == i, "R8 err_index", err_index, i);
                chk(cmd_ready && !elem_ready, "R8 abort", elem_ready, 0);
                aborted = 1'b1;
                break;
            end
            chk(!err_valid, "R10 elem no error", err_valid, 0);
            if (el_s[i] == 0) begin
                chk(!txn_valid, "R9 zero elem", txn_valid, 0);
            end else begin
                plan(lc, el_r[i], el_s[i]);
                collect(cls);
            end
            lc += el_s[i];
        end
        if (!aborted) chk(cmd_ready && !elem_ready, "R7 list end", cmd_ready, 1);
        el_r.delete(); el_s.delete();
    endtask

    function automatic int unsigned pick_size();
        int k = $urandom % 10;
        case (k)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 0;
            5: return 16 * (1 + $urandom % 16);
            6: return 16 * (1 + $urandom % 1024);
            7: return 3 + 16 * ($urandom % 4);
            8: return 16 * (1 + $urandom % 40);
            default: return $urandom % 32768;
        endcase
    endfunction

    function automatic int unsigned pick_addr(int unsigned s);
        int unsigned a = $urandom % 32'h1000_0000;
        if (($urandom % 6) == 0) return a;
        if (s >= 16) return a & ~32'hF;
        if (s == 0) return a;
        return a & ~(s - 1);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready && !txn_valid && !elem_ready && !err_valid, "R1 reset",
            {cmd_ready, txn_valid, elem_ready, err_valid}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !txn_valid && !elem_ready, "R11 idle phase", cmd_ready, 1);

        // directed singles
        run_single(32'h100, 32'h200, 8, 1);
        run_single(32'h101, 32'h203, 1, 2);
        run_single(32'h1000, 32'h2000, 128, 3);
        run_single(32'h4000, 32'h1030, 256, 0);
        run_single(32'h40, 32'h8040, 16384, 2);
        run_single(32'h10, 32'h10, 0, 1);            // R9
        run_single(32'h0, 32'h0, 3, 0);              // R2
        run_single(32'h0, 32'h0, 20, 0);             // R2
        run_single(32'h0, 32'h0, 16400, 0);          // R2
        run_single(32'h0, 32'h2, 4, 0);              // R3
        run_single(32'h0, 32'h8, 32, 0);             // R3
        run_single(32'h104, 32'h100, 16, 0);         // R3 local side
        run_single(32'h1, 32'h3, 17, 0);             // R3 precedence: size first

        // list count limits
        send_cmd(1'b1, 0, 0, 0, 1, 0, 3, "R7 count zero");
        send_cmd(1'b1, 0, 0, 0, 1, 2049, 3, "R7 count over");

        // mixed list with zero-size elements
        el_r = '{32'h3000, 32'h5008, 32'h6000, 32'h7070, 32'h7777};
        el_s = '{16, 8, 0, 144, 0};
        run_list(32'h800, 3);

        // list aborting at third element
        el_r = '{32'h100, 32'h200, 32'h301, 32'h400};
        el_s = '{16, 32, 16, 16};
        run_list(32'h0, 2);

        // random singles
        for (int i = 0; i < 60; i++) begin
            int unsigned s = pick_size();
            run_single(pick_addr(s), pick_addr(s), s, $urandom % 4);
        end

        // random lists
        for (int j = 0; j < 12; j++) begin
            int n = 1 + $urandom % 8;
            for (int i = 0; i < n; i++) begin
                int unsigned s = (($urandom % 3) == 0) ? (($urandom % 2) ? 0 : 8)
                                                       : 16 * ($urandom % 20);
                el_s.push_back(s);
                el_r.push_back(pick_addr(s));
            end
            run_list(32'h1_0000 * j, $urandom % 4);
        end

        // full-length list, then abort at final position 2047
        for (int i = 0; i < 2048; i++) begin
            el_s.push_back(1); el_r.push_back($urandom % 32'h100_0000);
        end
        run_list(32'h20_0000, 1);
        for (int i = 0; i < 2048; i++) begin
            el_s.push_back((i == 2047) ? 5 : 1); el_r.push_back($urandom % 32'h100_0000);
        end
        run_list(32'h30_0000, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule